// File: doc/BRIEF.md
# Linked-Descriptor Receive Word Mover

This block empties a receive FIFO of 32-bit words into system memory without processor help. Software builds a chain of buffer descriptors in memory, loads the address of the first one, and pulses an enable request. The mover then reads each descriptor, waits for words in the FIFO, and writes each word to the next slot of the buffer that the descriptor names. When a buffer is full, it hands the descriptor back to software by clearing its ownership bit, then follows the link to the next descriptor.

The enable bit is owned by the mover. It clears itself when the chain runs out (a zero link or a zero start address) or when a fetched descriptor still belongs to software. Each such self-stop sets a sticky status flag, which can raise the interrupt line. While the mover is enabled, the FIFO's data-available condition raises no interrupt, because the mover consumes that data itself. Software may also stop the mover. In that case, any memory or descriptor access already in progress completes first.

Top module: `rxdma_mover`

## Requirements
- R1: `irq_o` equals `(!en_o && fifo_avail) || (stop_flag && stop_ie)` in every cycle. While enabled, FIFO data never raises the interrupt.
- R2: While enabled, a FIFO word is popped only when `fifo_avail` is high. Popped words are written in pop order to buffer byte addresses base+0, base+4, base+8, and so on. Only one memory or descriptor access is outstanding at a time, and `mem_req`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`.
- R3: A descriptor is four words read from byte addresses P, P+4, P+8 and P+12. They hold, in that order, the buffer byte address, the buffer length in words, the owner word (bit 0: 1 = mover, 0 = software) and the next descriptor address.
- R4: After the last word of a buffer, the mover writes 0 to P+8 before it reads any other descriptor. A length of 0 leads straight to this write-back with no data words.
- R5: A next-descriptor address of 0, or a start address of 0, clears `en_o` and sets `stop_flag`.
- R6: A fetched descriptor whose owner bit is 0 clears `en_o` and sets `stop_flag`, without popping or writing anything.
- R7: `stop_flag` stays set until `flag_clr` is pulsed. It drives `irq_o` only when `stop_ie` is 1.
- R8: A pulse on `en_clr` lets the access in progress complete, then clears `en_o` without setting `stop_flag`. After that, no word is popped.
- R9: After reset, `en_o`, `stop_flag`, `fifo_pop`, `mem_req` and `dsc_req` are 0. A pulse on `en_set` while `en_o` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Start pulse from the register logic |
| en_clr | input | 1 | Software stop pulse |
| desc_base | input | 32 | First descriptor byte address, taken on `en_set` |
| stop_ie | input | 1 | Lets `stop_flag` reach `irq_o` |
| flag_clr | input | 1 | Clears `stop_flag` |
| en_o | output | 1 | Enable bit returned to the register logic |
| stop_flag | output | 1 | Sticky self-stop status |
| irq_o | output | 1 | Interrupt request |
| fifo_avail | input | 1 | FIFO holds at least one word |
| fifo_rdata | input | 32 | FIFO head word (first-word fall-through) |
| fifo_pop | output | 1 | Pops the head word at the clock edge |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write accepted at this edge |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | 32 | Descriptor word byte address |
| dsc_rdata | input | 32 | Descriptor word, valid with `dsc_ack` |
| dsc_ack | input | 1 | Descriptor read completes at this edge |

## Verification
`irq_o` is combinational, so the bench checks it against its own formula in every cycle, one nanosecond after the falling edge, once the inputs driven at that edge have settled. A pop takes effect at the next rising edge; the FIFO model therefore records `fifo_pop` in one cycle and removes the word at the following falling edge, and the data write for that word is requested one cycle after the pop. Each memory write is compared against the head of an expected queue at the falling edge where the model acknowledges it. `en_o` drops at the rising edge after the mover reaches a stop point, so the checks on `en_o`, `stop_flag`, leftover FIFO depth and descriptor write-backs wait, with a bounded count, until `en_o` is low before they sample.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  parameter int RXD_AW = 32;
  parameter int RXD_DW = 32;
  parameter int RXD_LW = 16;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int F_BUF  = 0;
  localparam int F_LEN  = 1;
  localparam int F_OWN  = 2;
  localparam int F_NEXT = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_FETCH, S_EVAL, S_WAIT, S_WRITE, S_WB
  } rx_state_e;

  // byte address of the k-th 32-bit word after base
  function automatic logic [RXD_AW-1:0] word_addr(input logic [RXD_AW-1:0] base,
                                                   input logic [RXD_AW-1:0] k);
    return base + (k << 2);
  endfunction

  // true when the word about to complete is the last one of the buffer
  function automatic logic buf_full(input logic [RXD_LW-1:0] done_cnt,
                                    input logic [RXD_LW-1:0] len);
    logic [RXD_LW:0] nxt;
    nxt = {1'b0, done_cnt} + {{RXD_LW{1'b0}}, 1'b1};
    return nxt == {1'b0, len};
  endfunction
endpackage

// File: rtl/rxdma_irq.sv
module rxdma_irq
  import rxdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fifo_avail,
  input  logic self_off,
  input  logic flag_clr,
  input  logic stop_ie,
  output logic stop_flag,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stop_flag <= 1'b0;
    else if (self_off) stop_flag <= 1'b1;
    else if (flag_clr) stop_flag <= 1'b0;
  end

  assign irq_o = (!en && fifo_avail) || (stop_flag && stop_ie);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag && !flag_clr |=> stop_flag);
  p_selfoff_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    self_off |=> stop_flag);
  p_dma_masks_fifo_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en && !stop_ie |-> !irq_o);
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic [RXD_AW-1:0] desc_base,
  output logic              en_o,
  output logic              self_off,
  input  logic              fifo_avail,
  input  logic [RXD_DW-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              mem_req,
  output logic [RXD_AW-1:0] mem_addr,
  output logic [RXD_DW-1:0] mem_wdata,
  input  logic              mem_ack,
  output logic              dsc_req,
  output logic [RXD_AW-1:0] dsc_addr,
  input  logic [RXD_DW-1:0] dsc_rdata,
  input  logic              dsc_ack
);
  rx_state_e         st_q;
  logic              en_q, stop_pend_q, own_q;
  logic [RXD_AW-1:0] ptr_q, buf_q, nxt_q;
  logic [RXD_LW-1:0] len_q, cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RXD_DW-1:0] wdata_q;

  // named internal events
  logic stop_now, stop_point, sw_off, last_word;
  assign stop_now   = stop_pend_q || en_clr;
  assign stop_point = (st_q == S_CHK) || (st_q == S_EVAL) || (st_q == S_WAIT);
  assign sw_off     = stop_now && stop_point;
  assign self_off   = !sw_off && (((st_q == S_CHK) && (ptr_q == '0)) ||
                                  ((st_q == S_EVAL) && !own_q));
  assign last_word  = buf_full(cnt_q, len_q);

  assign en_o      = en_q;
  assign fifo_pop  = (st_q == S_WAIT) && !stop_now && fifo_avail;
  assign dsc_req   = (st_q == S_FETCH);
  assign dsc_addr  = word_addr(ptr_q, RXD_AW'(idx_q));
  assign mem_req   = (st_q == S_WRITE) || (st_q == S_WB);
  assign mem_addr  = (st_q == S_WB) ? word_addr(ptr_q, RXD_AW'(F_OWN))
                                    : word_addr(buf_q, RXD_AW'(cnt_q));
  assign mem_wdata = (st_q == S_WB) ? '0 : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; en_q <= 1'b0; stop_pend_q <= 1'b0; own_q <= 1'b0;
      ptr_q <= '0; buf_q <= '0; nxt_q <= '0; len_q <= '0; cnt_q <= '0;
      idx_q <= '0; wdata_q <= '0;
    end else begin
      if (en_q && en_clr) stop_pend_q <= 1'b1;
      if (sw_off || self_off) begin
        st_q <= S_IDLE; en_q <= 1'b0; stop_pend_q <= 1'b0;
      end else begin
        unique case (st_q)
          S_IDLE: if (en_set) begin
            en_q <= 1'b1; ptr_q <= desc_base; stop_pend_q <= 1'b0; st_q <= S_CHK;
          end
          S_CHK: begin
            idx_q <= '0; st_q <= S_FETCH;
          end
          S_FETCH: if (dsc_ack) begin
            case (int'(idx_q))
              F_BUF:   buf_q <= dsc_rdata[RXD_AW-1:0];
              F_LEN:   len_q <= dsc_rdata[RXD_LW-1:0];
              F_OWN:   own_q <= dsc_rdata[0];
              default: nxt_q <= dsc_rdata[RXD_AW-1:0];
            endcase
            idx_q <= idx_q + 1'b1;
            if (int'(idx_q) == F_NEXT) st_q <= S_EVAL;
          end
          S_EVAL: begin
            cnt_q <= '0;
            st_q  <= (len_q == '0) ? S_WB : S_WAIT;
          end
          S_WAIT: if (fifo_avail) begin
            wdata_q <= fifo_rdata; st_q <= S_WRITE;
          end
          S_WRITE: if (mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= last_word ? S_WB : S_WAIT;
          end
          S_WB: if (mem_ack) begin
            ptr_q <= nxt_q; st_q <= S_CHK;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  p_pop_needs_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_avail);
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dsc_req));
  p_selfoff_drops_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    self_off |=> !en_o);
  p_no_pop_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> en_o);
  p_set_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_o && en_set && !en_clr && !stop_pend_q && !self_off |=> en_o);
endmodule

// File: rtl/rxdma_mover.sv
module rxdma_mover
  import rxdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic [RXD_AW-1:0] desc_base,
  input  logic              stop_ie,
  input  logic              flag_clr,
  output logic              en_o,
  output logic              stop_flag,
  output logic              irq_o,
  input  logic              fifo_avail,
  input  logic [RXD_DW-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              mem_req,
  output logic [RXD_AW-1:0] mem_addr,
  output logic [RXD_DW-1:0] mem_wdata,
  input  logic              mem_ack,
  output logic              dsc_req,
  output logic [RXD_AW-1:0] dsc_addr,
  input  logic [RXD_DW-1:0] dsc_rdata,
  input  logic              dsc_ack
);
  logic self_off;

  rxdma_engine u_eng (
    .clk, .rst_n, .en_set, .en_clr, .desc_base, .en_o, .self_off,
    .fifo_avail, .fifo_rdata, .fifo_pop,
    .mem_req, .mem_addr, .mem_wdata, .mem_ack,
    .dsc_req, .dsc_addr, .dsc_rdata, .dsc_ack
  );

  rxdma_irq u_irq (
    .clk, .rst_n, .en(en_o), .fifo_avail, .self_off, .flag_clr, .stop_ie,
    .stop_flag, .irq_o
  );
endmodule

// File: tb/sim_rxdma_mover.sv
module sim_rxdma_mover;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic en_set = 0, en_clr = 0, stop_ie = 0, flag_clr = 0;
  logic [31:0] desc_base = '0;
  logic en_o, stop_flag, irq_o, fifo_pop, mem_req, dsc_req;
  logic fifo_avail = 0, mem_ack = 0, dsc_ack = 0;
  logic [31:0] fifo_rdata = '0, dsc_rdata = '0, mem_addr, mem_wdata, dsc_addr;

  rxdma_mover u0 (.*);

  typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] fq [$];
  wr_t exq [$];
  int n_cmp = 0, n_bad = 0;
  int mem_dly = 0, dsc_dly = 0, mcnt = 0, dcnt = 0;
  bit pop_pend = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // FIFO, memory and descriptor models, plus the per-cycle reference checks
  always begin
    @(negedge clk);
    if (pop_pend) fq.delete(0);
    fifo_avail = fq.size() > 0;
    fifo_rdata = (fq.size() > 0) ? fq[0] : 32'h0;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (mcnt < mem_dly) mcnt++;
      else begin
        mcnt = 0; mem_ack = 1;
        mem[mem_addr] = mem_wdata;
        if (exq.size() == 0) chk(0, "R2", "unexpected write addr", mem_addr, 32'h0);
        else begin
          chk(mem_addr == exq[0].a, "R2/R3", "write addr", mem_addr, exq[0].a);
          chk(mem_wdata == exq[0].d, "R2/R4", "write data", mem_wdata, exq[0].d);
          exq.delete(0);
        end
      end
    end
    if (dsc_ack) dsc_ack = 0;
    else if (dsc_req) begin
      if (dcnt < dsc_dly) dcnt++;
      else begin
        dcnt = 0; dsc_ack = 1;
        dsc_rdata = mem.exists(dsc_addr) ? mem[dsc_addr] : 32'h0;
      end
    end
    #1;
    pop_pend = fifo_pop;
    if (rst_n) begin
      chk(irq_o == ((!en_o && fifo_avail) || (stop_flag && stop_ie)), "R1", "irq_o",
          {31'b0, irq_o}, {31'b0, ((!en_o && fifo_avail) || (stop_flag && stop_ie))});
      if (fifo_pop && !fifo_avail) chk(0, "R2", "pop while empty", 1, 0);
      if (fifo_pop && !en_o) chk(0, "R8", "pop while disabled", 1, 0);
      if (mem_req && dsc_req) chk(0, "R2", "two accesses outstanding", 1, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finish_run();
  end

  task automatic put_desc(input logic [31:0] p, input logic [31:0] b, input logic [31:0] len,
                          input logic [31:0] own, input logic [31:0] nxt);
    mem[p] = b; mem[p + 4] = len; mem[p + 8] = own; mem[p + 12] = nxt;
  endtask

  task automatic pulse_en(input logic [31:0] base);
    @(negedge clk); desc_base = base; en_set = 1;
    @(negedge clk); en_set = 0;
  endtask

  task automatic pulse_clr_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic wait_off();
    for (int n = 0; n < 500 && en_o; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic push_words(input logic [31:0] seed, input int n);
    for (int i = 0; i < n; i++) fq.push_back(seed + i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(en_o == 0, "R9", "reset en_o", en_o, 0);
    chk(stop_flag == 0, "R9", "reset stop_flag", stop_flag, 0);
    chk(mem_req == 0 && dsc_req == 0 && fifo_pop == 0, "R9", "reset requests",
        {mem_req, dsc_req, fifo_pop}, 0);

    // two-buffer chain ending on a zero link
    stop_ie = 1;
    push_words(32'hA000_0000, 5);
    repeat (3) @(negedge clk);
    chk(irq_o == 1, "R1", "fifo irq while disabled", irq_o, 1);
    chk(fq.size() == 5, "R8", "no pop while disabled", fq.size(), 5);
    put_desc(32'h100, 32'h1000, 3, 1, 32'h200);
    put_desc(32'h200, 32'h2000, 2, 1, 32'h0);
    for (int i = 0; i < 3; i++) exq.push_back('{32'h1000 + 4*i, 32'hA000_0000 + i});
    exq.push_back('{32'h108, 32'h0});
    for (int i = 0; i < 2; i++) exq.push_back('{32'h2000 + 4*i, 32'hA000_0003 + i});
    exq.push_back('{32'h208, 32'h0});
    pulse_en(32'h100);
    wait_off();
    chk(exq.size() == 0, "R3", "writes left", exq.size(), 0);
    chk(en_o == 0, "R5", "en_o after zero link", en_o, 0);
    chk(stop_flag == 1, "R5", "flag after zero link", stop_flag, 1);
    chk(irq_o == 1, "R7", "irq with flag unmasked", irq_o, 1);
    chk(mem[32'h108] == 0 && mem[32'h208] == 0, "R4", "owner written back",
        mem[32'h108] | mem[32'h208], 0);
    repeat (3) @(negedge clk);
    chk(stop_flag == 1, "R7", "flag sticky", stop_flag, 1);

    // descriptor still owned by software
    stop_ie = 0;
    pulse_clr_flag();
    chk(stop_flag == 0, "R7", "flag cleared", stop_flag, 0);
    push_words(32'hB000_0000, 3);
    put_desc(32'h300, 32'h3000, 2, 1, 32'h400);
    put_desc(32'h400, 32'h4000, 1, 0, 32'h0);
    exq.push_back('{32'h3000, 32'hB000_0000});
    exq.push_back('{32'h3004, 32'hB000_0001});
    exq.push_back('{32'h308, 32'h0});
    pulse_en(32'h300);
    wait_off();
    chk(exq.size() == 0, "R6", "writes left", exq.size(), 0);
    chk(stop_flag == 1, "R6", "flag on software owner", stop_flag, 1);
    chk(fq.size() == 1, "R6", "no word taken for software descriptor", fq.size(), 1);
    chk(mem[32'h408] == 0 && !mem.exists(32'h4000), "R6", "software descriptor untouched",
        mem[32'h408], 0);
    chk(irq_o == 1, "R1", "fifo irq after disable", irq_o, 1);
    fq.delete();

    // software stop while waiting for data, with an ignored start pulse
    pulse_clr_flag();
    put_desc(32'h500, 32'h5000, 8, 1, 32'h0);
    push_words(32'hC000_0000, 3);
    for (int i = 0; i < 3; i++) exq.push_back('{32'h5000 + 4*i, 32'hC000_0000 + i});
    pulse_en(32'h500);
    pulse_en(32'h300);
    for (int n = 0; n < 200 && exq.size() > 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(en_o == 1, "R9", "en_set while enabled ignored", en_o, 1);
    @(negedge clk); en_clr = 1;
    @(negedge clk); en_clr = 0;
    wait_off();
    chk(en_o == 0, "R8", "en_o after software stop", en_o, 0);
    chk(stop_flag == 0, "R8", "no flag on software stop", stop_flag, 0);
    push_words(32'hC100_0000, 2);
    repeat (10) @(negedge clk);
    chk(fq.size() == 2, "R8", "no pop after stop", fq.size(), 2);
    fq.delete();

    // software stop during a slow write
    mem_dly = 6;
    put_desc(32'h600, 32'h6000, 4, 1, 32'h0);
    push_words(32'hD000_0000, 4);
    exq.push_back('{32'h6000, 32'hD000_0000});
    pulse_en(32'h600);
    for (int n = 0; n < 200 && !mem_req; n++) @(negedge clk);
    en_clr = 1;
    @(negedge clk); en_clr = 0;
    chk(mem_req == 1, "R8", "write in progress kept", mem_req, 1);
    wait_off();
    chk(exq.size() == 0, "R8", "pending write completed", exq.size(), 0);
    chk(fq.size() == 3, "R8", "later words left", fq.size(), 3);
    chk(stop_flag == 0, "R8", "no flag", stop_flag, 0);
    fq.delete();
    mem_dly = 0;

    // zero start address
    pulse_en(32'h0);
    wait_off();
    chk(en_o == 0 && stop_flag == 1, "R5", "zero start address", {en_o, stop_flag}, 2'b01);

    // zero-length buffer, slow descriptor reads
    pulse_clr_flag();
    dsc_dly = 2;
    put_desc(32'h700, 32'h7000, 0, 1, 32'h0);
    exq.push_back('{32'h708, 32'h0});
    pulse_en(32'h700);
    wait_off();
    chk(exq.size() == 0, "R4", "zero length write-back only", exq.size(), 0);
    chk(stop_flag == 1, "R5", "flag after zero-length chain", stop_flag, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule